// File: doc/BRIEF.md
# Byte-Word Memory Access Aligner

This block sits between a processor-side load/store port and an external memory bus that is 16 bits wide and carries a 20-bit byte address. The processor may ask for a byte or a 16-bit word, for a read or a write, at any byte address. The bus accepts only even addresses. The block breaks each request into one or two aligned bus cycles and moves bytes between lanes in little-endian order. On reads it joins the wanted bytes into a single result. On writes it drives byte enables so that only the intended bytes change.

A request is taken when `reqValid` is high while `reqReady` is high. `reqReady` is high only while the block is idle. Each bus cycle keeps its address, enables and write data until `memReady` is high on a clock edge. When the final bus cycle ends, `done` pulses for one cycle. For a read, `rdata` then holds the assembled value.

A word at an odd address N needs two bus cycles. The first is at N-1 and supplies its odd lane as the low result byte. The second is at N+1 and supplies its even lane as the high result byte. The other two bytes fetched are dropped. A byte read fetches both lanes and keeps only the one addressed.

Top module: `byteword_aligner`

## Requirements
- R1: While reset is asserted and right after it, `reqReady` is 1, `memValid` is 0 and `done` is 0.
- R2: A request is captured only on an edge where `reqReady` is high. `reqReady` is low from the cycle after capture until the transaction ends. A `reqValid` presented while busy is ignored and creates no bus cycle and no extra `done`.
- R3: `memAddr` always has bit 0 equal to 0. The first bus cycle of a request uses the request address with bit 0 cleared.
- R4: A word access at an even address uses exactly one bus cycle. A word read returns `memRdata` unchanged (lane 0 = bits 7:0 = low byte).
- R5: A word access at an odd address N uses exactly two bus cycles, at N-1 and then N+1. The read result is {lane 0 of the second cycle, lane 1 of the first cycle}.
- R6: A byte read uses one bus cycle with `memBe` = 2'b11. The result holds the byte from lane `addr[0]` in bits 7:0, and bits 15:8 are zero.
- R7: On writes, `memBe` bit 0 enables lane 0 (bits 7:0) and bit 1 enables lane 1 (bits 15:8). The values are 2'b11 for an even word, 2'b01 for an even byte, and 2'b10 for an odd byte. An odd word uses 2'b10 with the low data byte on lane 1, then 2'b01 with the high data byte on lane 0. Every write data byte appears on its enabled lane.
- R8: While `memValid` is high and `memReady` is low on an edge, `memAddr`, `memBe` and `memWdata` stay unchanged in the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the edge on which the last bus cycle sees `memReady`. `rdata` keeps its value until the next read completes.
- R10: An odd word access at address FFFFFh runs its second bus cycle at address 00000h.
- R11: The block may accept a new request on the edge that ends a `done` cycle, so transactions can run back to back without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqAddr | input | 20 | Byte address of the request |
| reqWdata | input | 16 | Write data; a byte write uses bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read result |
| memValid | output | 1 | Bus cycle in progress |
| memWrite | output | 1 | Bus cycle is a write |
| memAddr | output | 20 | Even bus address |
| memBe | output | 2 | Per-lane byte enables |
| memWdata | output | 16 | Bus write data |
| memRdata | input | 16 | Bus read data |
| memReady | input | 1 | Bus cycle completes on this edge |

## Verification
The completion pulse of one transaction can fall in the same cycle as the acceptance of the next request, because the block returns to idle together with `done`. The bench keeps the next request waiting on `reqValid` while a transaction runs, so the capture edge lands on the `done` cycle. The random memory wait states move that overlap across all the request kinds. The bench counts these overlaps and requires at least one. It also checks, for both transactions around each overlap, that the bus beats and the returned data belong to the right request and that no completion arrives without a matching request.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } alignState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;       // latch the incoming request
    logic busActive;     // a bus cycle is being presented
    logic secondBeat;    // the current bus cycle is the upper half of a split word
    logic splitAdvance;  // first half of a split word completes this edge
    logic finish;        // last bus cycle completes this edge
  } alignStrobes_t;

endpackage

// File: rtl/aligner_ctrl.sv
module aligner_ctrl
  import aligner_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          memReady,
  input  logic          split,
  output logic          reqReady,
  output alignStrobes_t strobes
);

  alignState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (reqValid) stateD = ST_FIRST;
      ST_FIRST:  if (memReady) stateD = split ? ST_SECOND : ST_IDLE;
      ST_SECOND: if (memReady) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    reqReady             = (stateQ == ST_IDLE);
    strobes.capture      = (stateQ == ST_IDLE) && reqValid;
    strobes.busActive    = (stateQ != ST_IDLE);
    strobes.secondBeat   = (stateQ == ST_SECOND);
    strobes.splitAdvance = (stateQ == ST_FIRST) && memReady && split;
    strobes.finish       = memReady && (((stateQ == ST_FIRST) && !split) ||
                                        (stateQ == ST_SECOND));
  end

  // R2: after a capture the block is busy and closed to new requests
  assert_busy_after_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (strobes.busActive && !reqReady));

  // R5: the first half of a split word is always followed by the second half
  assert_split_second_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.splitAdvance |=> strobes.secondBeat);

  // R11: completion returns the block to idle at once
  assert_finish_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> reqReady);

endmodule

// File: rtl/aligner_datapath.sv
module aligner_datapath
  import aligner_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  alignStrobes_t     strobes,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              split,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memBe,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  logic [ADDR_W-1:0] addrQ;
  logic              wordQ, writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BYTE_W-1:0] lowByteQ;
  logic [DATA_W-1:0] rdataQ;
  logic              doneQ;

  logic [ADDR_W-1:0] evenBase, nextBase;
  logic [1:0]        wantMask;
  logic              oddAddr;
  logic [BYTE_W-1:0] laneRd [LANES];
  logic [BYTE_W-1:0] laneWr [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wordQ  <= 1'b0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strobes.capture) begin
      addrQ  <= reqAddr;
      wordQ  <= reqWord;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
    end
  end

  assign oddAddr  = addrQ[0];
  assign split    = wordQ && oddAddr;
  assign evenBase = {addrQ[ADDR_W-1:1], 1'b0};
  assign nextBase = evenBase + ADDR_W'(2);
  assign memAddr  = strobes.secondBeat ? nextBase : evenBase;

  // lanes this bus cycle really wants
  always_comb begin
    if (strobes.secondBeat)      wantMask = 2'b01;
    else if (wordQ && !oddAddr)  wantMask = 2'b11;
    else if (oddAddr)            wantMask = 2'b10;
    else                         wantMask = 2'b01;
  end

  assign memWrite = strobes.busActive && writeQ;
  assign memBe    = !strobes.busActive ? 2'b00 : (writeQ ? wantMask : 2'b11);

  // per-lane write steering and read extraction
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneRd[l] = memRdata[l*BYTE_W +: BYTE_W];
    assign memWdata[l*BYTE_W +: BYTE_W] = laneWr[l];
  end

  always_comb begin
    laneWr[0] = strobes.secondBeat ? wdataQ[15:8] : wdataQ[7:0];
    laneWr[1] = (wordQ && !oddAddr && !strobes.secondBeat) ? wdataQ[15:8] : wdataQ[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowByteQ <= '0;
      rdataQ   <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobes.finish;
      if (strobes.splitAdvance && !writeQ) lowByteQ <= laneRd[1];
      if (strobes.finish && !writeQ) begin
        if (strobes.secondBeat)  rdataQ <= {laneRd[0], lowByteQ};
        else if (wordQ)          rdataQ <= memRdata;
        else                     rdataQ <= {{BYTE_W{1'b0}}, oddAddr ? laneRd[1] : laneRd[0]};
      end
    end
  end

  assign rdata = rdataQ;
  assign done  = doneQ;

  // R5 and R10: second half steps two bytes up, wrapping at the top of the space
  assert_split_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.splitAdvance) |-> (memAddr == ADDR_W'($past(memAddr) + ADDR_W'(2))));

  // R7: a byte write touches exactly one lane
  assert_byte_write_lane_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busActive && writeQ && !wordQ) |-> ($countones(memBe) == 1));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/byteword_aligner.sv
module byteword_aligner
  import aligner_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady
);

  alignStrobes_t strobes;
  logic          split;

  aligner_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memReady (memReady),
    .split    (split),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  aligner_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .split    (split),
    .memAddr  (memAddr),
    .memBe    (memBe),
    .memWrite (memWrite),
    .memWdata (memWdata),
    .rdata    (rdata),
    .done     (done)
  );

  assign memValid = strobes.busActive;

  // R8: a stalled bus cycle keeps every control and data field
  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memBe) &&
                                 $stable(memWdata) && $stable(memWrite)));

  // R7: a write bus cycle always enables at least one lane
  assert_write_enables_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> (memBe != 2'b00));

  // R1: reset leaves the block idle with no bus activity
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (reqReady && !memValid && !done));

endmodule

// File: tb/byteword_aligner_test.sv
module byteword_aligner_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqWrite, reqWord;
  logic [19:0] reqAddr;
  logic [15:0] reqWdata;
  logic        done;
  logic [15:0] rdata;
  logic        memValid, memWrite;
  logic [19:0] memAddr;
  logic [1:0]  memBe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        memReady;

  always #5 clk = ~clk;

  byteword_aligner uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .done(done), .rdata(rdata), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady)
  );

  typedef struct packed { logic wr; logic word; logic [19:0] addr; logic [15:0] data; } reqRec_t;
  typedef struct packed { logic [19:0] addr; logic [1:0] be; logic wr; logic [15:0] wdata; } beatRec_t;

  reqRec_t  expQ[$];
  beatRec_t beatQ[$];
  int checks = 0, errors = 0, overlaps = 0, cycleCnt = 0, waitCnt = 0;
  logic        holding = 1'b0, prevDone = 1'b0;
  logic [19:0] holdAddr;
  logic [1:0]  holdBe;
  logic [15:0] holdWdata, heldRdata = '0;

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] expRead(input reqRec_t e);
    logic [19:0] a1 = e.addr + 20'd1;
    return e.word ? {memByte(a1), memByte(e.addr)} : {8'h00, memByte(e.addr)};
  endfunction

  function automatic logic [1:0] expBe(input reqRec_t e, input int beat);
    if (!e.wr) return 2'b11;
    if (beat == 1) return 2'b01;
    if (e.word && !e.addr[0]) return 2'b11;
    return e.addr[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [15:0] expWdata(input reqRec_t e, input int beat);
    if (beat == 1) return {8'h00, e.data[15:8]};
    if (e.word && !e.addr[0]) return e.data;
    return e.addr[0] ? {e.data[7:0], 8'h00} : {8'h00, e.data[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic verifyTxn(input reqRec_t e);
    string kind;
    int    nBeats;
    kind   = (e.word && e.addr[0]) ? "R5" : (e.word ? "R4" : (e.wr ? "R7" : "R6"));
    nBeats = (e.word && e.addr[0]) ? 2 : 1;
    check(beatQ.size() == nBeats, kind, "bus cycle count", beatQ.size(), nBeats);
    for (int i = 0; i < beatQ.size() && i < nBeats; i++) begin
      logic [19:0] ea;
      logic [15:0] wm;
      ea = {e.addr[19:1], 1'b0} + 20'(2 * i);
      check(beatQ[i].addr == ea, (e.addr == 20'hFFFFF && i == 1) ? "R10" : "R3",
            "bus address", beatQ[i].addr, ea);
      check(beatQ[i].be == expBe(e, i), e.wr ? "R7" : "R6", "byte enables", beatQ[i].be, expBe(e, i));
      check(beatQ[i].wr == e.wr, "R7", "bus direction", beatQ[i].wr, e.wr);
      if (e.wr) begin
        wm = {{8{expBe(e, i)[1]}}, {8{expBe(e, i)[0]}}};
        check((beatQ[i].wdata & wm) == expWdata(e, i), "R7", "lane write data",
              beatQ[i].wdata & wm, expWdata(e, i));
      end
    end
    if (!e.wr) begin
      check(rdata == expRead(e), kind, "read result", rdata, expRead(e));
      heldRdata = expRead(e);
    end
    beatQ.delete();
  endtask

  // monitor and memory responder, all at the falling edge
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      cycleCnt++;
      if (cycleCnt > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycleCnt);
        endRun();
      end
      if (done) begin
        check(!prevDone, "R9", "done longer than one cycle", 1, 0);
        if (expQ.size() == 0) check(1'b0, "R2", "completion without request", 1, 0);
        else verifyTxn(expQ.pop_front());
      end else if (prevDone) begin
        check(rdata == heldRdata, "R9", "rdata held after done", rdata, heldRdata);
      end
      prevDone = done;
      if (memValid) begin
        if (holding)
          check(memAddr == holdAddr && memBe == holdBe && memWdata == holdWdata, "R8",
                "stalled bus cycle changed", {memBe, memAddr}, {holdBe, holdAddr});
        if (waitCnt == 0) begin
          memReady = 1'b1;
          memRdata = {memByte(memAddr + 20'd1), memByte(memAddr)};
          beatQ.push_back('{memAddr, memBe, memWrite, memWdata});
          waitCnt  = $urandom % 4;
          holding  = 1'b0;
        end else begin
          memReady  = 1'b0;
          waitCnt--;
          holding   = 1'b1;
          holdAddr  = memAddr;
          holdBe    = memBe;
          holdWdata = memWdata;
        end
      end else begin
        memReady = 1'b0;
        holding  = 1'b0;
      end
    end
  end

  task automatic sendReq(input logic wr, input logic word, input logic [19:0] a,
                         input logic [15:0] d, input bit junk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = word; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    if (done) overlaps++;
    expQ.push_back('{wr, word, a, d});
    @(posedge clk);
    #1 reqValid = 1'b0;
    if (junk) begin
      @(negedge clk);
      check(!reqReady, "R2", "reqReady while busy", reqReady, 0);
      reqValid = 1'b1; reqWrite = ~wr; reqWord = ~word; reqAddr = a ^ 20'h00005;
      @(posedge clk);
      #1 reqValid = 1'b0;
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqWord = 1'b0;
    reqAddr = '0; reqWdata = '0; memReady = 1'b0; memRdata = '0;
    repeat (2) @(negedge clk);
    check(reqReady && !memValid && !done, "R1", "state in reset",
          {reqReady, memValid, done}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !memValid && !done, "R1", "state after reset",
          {reqReady, memValid, done}, 3'b100);

    // directed corners
    sendReq(1'b0, 1'b1, 20'hFFFFF, 16'h0000, 1'b0);  // R10 read wrap
    sendReq(1'b1, 1'b1, 20'hFFFFF, 16'hBEEF, 1'b0);  // R10 write wrap
    sendReq(1'b0, 1'b1, 20'h02000, 16'h0000, 1'b1);  // R4 with ignored request R2
    sendReq(1'b0, 1'b1, 20'h30151, 16'h0000, 1'b0);  // R5
    sendReq(1'b0, 1'b0, 20'h30156, 16'h0000, 1'b0);  // R6 even
    sendReq(1'b0, 1'b0, 20'h30157, 16'h0000, 1'b1);  // R6 odd with ignored request R2
    sendReq(1'b1, 1'b0, 20'h00010, 16'h12A5, 1'b0);  // R7 even byte
    sendReq(1'b1, 1'b0, 20'h00011, 16'h34C3, 1'b0);  // R7 odd byte
    sendReq(1'b1, 1'b1, 20'h00021, 16'h5678, 1'b0);  // R7 odd word
    sendReq(1'b1, 1'b1, 20'hFFFFE, 16'h9ABC, 1'b0);  // R4 top aligned word

    // constrained random traffic, no idle gap so done and capture coincide (R11)
    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      a = 20'($urandom);
      if ($urandom % 8 == 0) a = 20'hFFFFF - 20'($urandom % 4);
      if ($urandom % 6 == 0) repeat ($urandom % 3) @(negedge clk);
      sendReq(1'($urandom), 1'($urandom), a, 16'($urandom), ($urandom % 16) == 0);
    end

    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(overlaps > 0, "R11", "done cycle also accepting a request", overlaps, 1);
    check(reqReady && !memValid, "R2", "idle at end", {reqReady, memValid}, 2'b10);
    endRun();
  end

endmodule